// File: doc/BRIEF.md
# Sixteen-bit ALU with status flags and high-word register

This block is the arithmetic and logic stage of a small register-based processor. Each cycle it takes a first operand and a second operand. The second operand is either a register value or a sign-extended immediate, and a mode bit picks which one. An operation code selects what the block does with them. The result is combinational and appears in the same cycle. The decoder writes it back to the register file.

Four status flags are held in registers: carry, zero, sign and overflow. A multiply produces the full double-width product. The low half is the result, and the high half is held in a dedicated high-word register. A later move-from-high operation copies that register out through the result. The flags and the high word change only on a clock edge where the flag-enable strobe is high.

Operation codes (4 bits):
- 0: move-from-high
- 1: move
- 2: add
- 3: subtract
- 4: multiply
- 5: OR
- 6: AND
- 7: XOR
- 8: XNOR
- 9: NAND
- 10: NOR
- 11: NOT

Codes 12 to 15 are unused.

Top module: `flag_alu`

## Requirements
- R1: After a synchronous active-high reset, all four flags and the high-word register read 0.
- R2: When `imm_mode` is 1, the second operand is `imm` sign-extended from IMM_W bits, where bit IMM_W-1 is the sign. When `imm_mode` is 0, the second operand is `opb_reg`.
- R3: For add (code 2), the result is (a+b) mod 2^16, and carry is bit 16 of the 17-bit sum. Overflow is set when a and b have the same sign bit and the result's sign bit differs from it.
- R4: For subtract (code 3), the result is (a-b) mod 2^16, and carry is the borrow, set when a < b unsigned. Overflow is set when a and b differ in sign and the result's sign differs from a's sign.
- R5: For multiply (code 4), the result is the low 16 bits of the unsigned 32-bit product. When the flags are enabled, the high-word register takes the upper 16 bits. Carry and overflow are 0.
- R6: Codes 5 to 10 give a OR b, a AND b, a XOR b, XNOR, NAND and NOR, in that order. Code 11 gives NOT a and ignores the second operand. All seven of these clear carry and overflow.
- R7: Move (code 1) returns the second operand. Move-from-high (code 0) returns the high-word register. Both clear carry and overflow.
- R8: For every used code with flags enabled, zero is set exactly when the 16-bit result is 0, and sign equals result bit 15.
- R9: On an edge where `flag_en` is 0, the flags and the high-word register keep their values.
- R10: The high-word register changes only on an edge where `flag_en` is 1 and the code is multiply.
- R11: Unused codes 12 to 15 give a result of 0 and leave the flags and the high-word register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| imm_mode | input | 1 | 1 selects the sign-extended immediate as the second operand |
| opa | input | 16 | First operand |
| opb_reg | input | 16 | Second operand taken from a register |
| imm | input | IMM_W (8) | Immediate field |
| flag_en | input | 1 | Strobe that lets the flags and the high word update |
| result | output | 16 | Combinational result |
| carry_q | output | 1 | Carry/borrow flag |
| zero_q | output | 1 | Zero flag |
| sign_q | output | 1 | Sign flag |
| ovf_q | output | 1 | Overflow flag |
| hi_word | output | 16 | High half of the last enabled multiply |

## Verification
The assertions take for granted that `op_sel`, `opa`, `opb_reg`, `imm`, `imm_mode` and `flag_en` are steady around each rising edge. They relate the registered flags to the result seen in the previous cycle. The stimulus meets this by changing every input only on the falling edge, one operation per cycle. It mixes immediate and register forms, and it includes cycles with the strobe low and cycles with unused codes, so that the holding properties are exercised as well as the updating ones.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [3:0] {
        OP_MOVHI = 4'd0,
        OP_MOV   = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_MUL   = 4'd4,
        OP_OR    = 4'd5,
        OP_AND   = 4'd6,
        OP_XOR   = 4'd7,
        OP_XNOR  = 4'd8,
        OP_NAND  = 4'd9,
        OP_NOR   = 4'd10,
        OP_NOT   = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
    } flags_t;

    function automatic logic op_is_used(input logic [3:0] code);
        return code <= 4'd11;
    endfunction

    function automatic logic op_is_logic(input logic [3:0] code);
        return (code >= 4'd5) && (code <= 4'd11);
    endfunction

endpackage

// File: rtl/flag_alu_operand.sv
module flag_alu_operand #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              use_imm,
    output logic [DATA_W-1:0] operand
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        end else begin : g_trunc
            assign imm_ext = imm_val[DATA_W-1:0];
        end
    endgenerate

    assign operand = use_imm ? imm_ext : reg_val;
endmodule

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic [DATA_W-1:0] prod_hi,
    output logic              carry,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]     sum_w;
    logic [DATA_W:0]     dif_w;
    logic [2*DATA_W-1:0] prod_w;

    assign sum_w   = {1'b0, a} + {1'b0, b};
    assign dif_w   = {1'b0, a} - {1'b0, b};
    assign prod_w  = a * b;
    assign prod_hi = prod_w[2*DATA_W-1:DATA_W];

    always_comb begin
        res   = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        case (op)
            OP_ADD: begin
                res   = sum_w[MSB:0];
                carry = sum_w[DATA_W];
                ovf   = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
            end
            OP_SUB: begin
                res   = dif_w[MSB:0];
                carry = dif_w[DATA_W];
                ovf   = (a[MSB] != b[MSB]) && (dif_w[MSB] != a[MSB]);
            end
            OP_MUL: res = prod_w[MSB:0];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        case (op)
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_XNOR: res = ~(a ^ b);
            OP_NAND: res = ~(a & b);
            OP_NOR:  res = ~(a | b);
            OP_NOT:  res = ~a;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/flag_alu_state.sv
module flag_alu_state
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flags_we,
    input  flags_t            flags_d,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] hi_d,
    output flags_t            flags_q,
    output logic [DATA_W-1:0] hi_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            hi_q    <= '0;
        end else begin
            if (flags_we) flags_q <= flags_d;
            if (hi_we)    hi_q    <= hi_d;
        end
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_sel,
    input  logic              imm_mode,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic              flag_en,
    output logic [DATA_W-1:0] result,
    output logic              carry_q,
    output logic              zero_q,
    output logic              sign_q,
    output logic              ovf_q,
    output logic [DATA_W-1:0] hi_word
);
    alu_op_e           op;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] ar_res;
    logic [DATA_W-1:0] ar_hi;
    logic              ar_c;
    logic              ar_v;
    logic [DATA_W-1:0] lg_res;
    flags_t            flags_d;
    flags_t            flags_q;

    assign op = alu_op_e'(op_sel);

    flag_alu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
        .reg_val (opb_reg),
        .imm_val (imm),
        .use_imm (imm_mode),
        .operand (opb)
    );

    flag_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .op      (op),
        .a       (opa),
        .b       (opb),
        .res     (ar_res),
        .prod_hi (ar_hi),
        .carry   (ar_c),
        .ovf     (ar_v)
    );

    flag_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .op  (op),
        .a   (opa),
        .b   (opb),
        .res (lg_res)
    );

    always_comb begin
        case (op)
            OP_MOVHI:              result = hi_word;
            OP_MOV:                result = opb;
            OP_ADD, OP_SUB, OP_MUL: result = ar_res;
            default:               result = op_is_logic(op_sel) ? lg_res : '0;
        endcase
    end

    always_comb begin
        flags_d.c = ar_c;
        flags_d.v = ar_v;
        flags_d.z = (result == '0);
        flags_d.s = result[DATA_W-1];
    end

    flag_alu_state #(.DATA_W(DATA_W)) u_state (
        .clk      (clk),
        .rst      (rst),
        .flags_we (flag_en && op_is_used(op_sel)),
        .flags_d  (flags_d),
        .hi_we    (flag_en && (op == OP_MUL)),
        .hi_d     (ar_hi),
        .flags_q  (flags_q),
        .hi_q     (hi_word)
    );

    assign carry_q = flags_q.c;
    assign zero_q  = flags_q.z;
    assign sign_q  = flags_q.s;
    assign ovf_q   = flags_q.v;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_sel,
    input logic              flag_en,
    input logic [DATA_W-1:0] result,
    input logic              carry_q,
    input logic              zero_q,
    input logic              sign_q,
    input logic              ovf_q,
    input logic [DATA_W-1:0] hi_word
);
    logic used_upd;
    assign used_upd = flag_en && (op_sel <= 4'd11);

    // R9
    p_hold_flags_r9: assert property (@(posedge clk) disable iff (rst)
        !flag_en |=> $stable({carry_q, zero_q, sign_q, ovf_q, hi_word}));

    // R8
    p_zero_sign_r8: assert property (@(posedge clk) disable iff (rst)
        used_upd |=> (zero_q == ($past(result) == '0)) && (sign_q == $past(result[DATA_W-1])));

    // R6
    p_logic_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (flag_en && op_sel >= 4'd5 && op_sel <= 4'd11) |=> (!carry_q && !ovf_q));

    // R10
    p_hi_only_mul_r10: assert property (@(posedge clk) disable iff (rst)
        !(flag_en && op_sel == 4'd4) |=> $stable(hi_word));

    // R11
    p_unused_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (op_sel > 4'd11) |=> $stable({carry_q, zero_q, sign_q, ovf_q, hi_word}));

    // R7
    p_move_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_en && op_sel <= 4'd1) |=> (!carry_q && !ovf_q));
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_sel  (op_sel),
    .flag_en (flag_en),
    .result  (result),
    .carry_q (carry_q),
    .zero_q  (zero_q),
    .sign_q  (sign_q),
    .ovf_q   (ovf_q),
    .hi_word (hi_word)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;
    localparam int DW = 16;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    op_sel = '0;
    logic          imm_mode = 1'b0;
    logic [DW-1:0] opa = '0;
    logic [DW-1:0] opb_reg = '0;
    logic [IW-1:0] imm = '0;
    logic          flag_en = 1'b0;
    logic [DW-1:0] result;
    logic          carry_q, zero_q, sign_q, ovf_q;
    logic [DW-1:0] hi_word;

    always #5 clk = ~clk;

    flag_alu #(.DATA_W(DW), .IMM_W(IW)) i_flag_alu (
        .clk(clk), .rst(rst), .op_sel(op_sel), .imm_mode(imm_mode),
        .opa(opa), .opb_reg(opb_reg), .imm(imm), .flag_en(flag_en),
        .result(result), .carry_q(carry_q), .zero_q(zero_q),
        .sign_q(sign_q), .ovf_q(ovf_q), .hi_word(hi_word)
    );

    typedef struct {
        logic [DW-1:0] res;
        logic [3:0]    fl;
        logic [DW-1:0] hi;
        string         tag;
    } item_t;

    item_t   sb_q[$];
    int      n_checks = 0;
    int      n_fails  = 0;
    bit      done     = 0;

    logic [3:0]    m_fl = '0;
    logic [DW-1:0] m_hi = '0;

    task automatic drive(input logic [3:0] op, input logic [DW-1:0] a,
                         input logic [DW-1:0] breg, input logic [IW-1:0] im,
                         input logic mode, input logic en, input string tag);
        logic [DW-1:0] b, r;
        logic [DW:0]   w;
        logic [2*DW-1:0] p;
        logic c, v;
        item_t it;
        b = mode ? {{(DW-IW){im[IW-1]}}, im} : breg;
        c = 0; v = 0; r = '0;
        p = a * b;
        case (op)
            4'd0: r = m_hi;
            4'd1: r = b;
            4'd2: begin w = a + b; r = w[DW-1:0]; c = w[DW];
                        v = (a[DW-1] == b[DW-1]) && (r[DW-1] != a[DW-1]); end
            4'd3: begin r = a - b; c = (a < b);
                        v = (a[DW-1] != b[DW-1]) && (r[DW-1] != a[DW-1]); end
            4'd4: r = p[DW-1:0];
            4'd5: r = a | b;
            4'd6: r = a & b;
            4'd7: r = a ^ b;
            4'd8: r = ~(a ^ b);
            4'd9: r = ~(a & b);
            4'd10: r = ~(a | b);
            4'd11: r = ~a;
            default: r = '0;
        endcase
        if (en && op <= 4'd11) m_fl = {c, (r == '0), r[DW-1], v};
        if (en && op == 4'd4)  m_hi = p[2*DW-1:DW];
        @(negedge clk);
        op_sel = op; opa = a; opb_reg = breg; imm = im; imm_mode = mode; flag_en = en;
        it.res = r; it.fl = m_fl; it.hi = m_hi; it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_checks++;
                if (result !== it.res || {carry_q, zero_q, sign_q, ovf_q} !== it.fl
                    || hi_word !== it.hi) begin
                    n_fails++;
                    $display("FAIL %s: res=%h flags=%b hi=%h expected res=%h flags=%b hi=%h",
                             it.tag, result, {carry_q, zero_q, sign_q, ovf_q}, hi_word,
                             it.res, it.fl, it.hi);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        n_checks++;
        if ({carry_q, zero_q, sign_q, ovf_q} !== 4'b0 || hi_word !== '0) begin
            n_fails++;
            $display("FAIL R1: flags=%b hi=%h expected flags=0000 hi=0000",
                     {carry_q, zero_q, sign_q, ovf_q}, hi_word);
        end
        // R3 add with carry out and zero result
        drive(4'd2, 16'hFFFF, 16'h0001, 8'h00, 0, 1, "R3 add carry, R8 zero");
        drive(4'd2, 16'h7FFF, 16'h0001, 8'h00, 0, 1, "R3 add overflow, R8 sign");
        drive(4'd2, 16'h8000, 16'h8000, 8'h00, 0, 1, "R3 add neg overflow");
        drive(4'd2, 16'h1234, 16'h0000, 8'hFE, 1, 1, "R2 imm negative add");
        drive(4'd1, 16'h0000, 16'hAAAA, 8'h7F, 1, 1, "R2 imm positive mov");
        // R4 subtract
        drive(4'd3, 16'h0001, 16'h0002, 8'h00, 0, 1, "R4 sub borrow");
        drive(4'd3, 16'h8000, 16'h0001, 8'h00, 0, 1, "R4 sub overflow");
        drive(4'd3, 16'h0050, 16'h0050, 8'h00, 0, 1, "R4 sub equal, R8 zero");
        drive(4'd3, 16'h0003, 16'h0000, 8'h01, 1, 1, "R4 sub imm");
        // R5 multiply and R7 move-from-high
        drive(4'd4, 16'hFFFF, 16'hFFFF, 8'h00, 0, 1, "R5 mul max");
        drive(4'd0, 16'h1111, 16'h2222, 8'h00, 0, 1, "R7 movhi");
        drive(4'd4, 16'h1234, 16'h0000, 8'hFF, 1, 0, "R10 mul without enable, R9");
        drive(4'd0, 16'h0000, 16'h0000, 8'h00, 0, 1, "R10 movhi after disabled mul");
        drive(4'd4, 16'h0100, 16'h0100, 8'h00, 0, 1, "R5 mul zero low");
        drive(4'd1, 16'h0000, 16'h8001, 8'h00, 0, 1, "R7 mov reg");
        // R6 logic set
        drive(4'd5, 16'hF0F0, 16'h0FF0, 8'h00, 0, 1, "R6 or");
        drive(4'd6, 16'hF0F0, 16'h0FF0, 8'h00, 0, 1, "R6 and");
        drive(4'd7, 16'hF0F0, 16'h0FF0, 8'h00, 0, 1, "R6 xor");
        drive(4'd8, 16'hF0F0, 16'h0FF0, 8'h00, 0, 1, "R6 xnor");
        drive(4'd9, 16'hF0F0, 16'h0FF0, 8'h00, 0, 1, "R6 nand");
        drive(4'd10, 16'hF0F0, 16'h0FF0, 8'h00, 0, 1, "R6 nor");
        drive(4'd2, 16'hFFFF, 16'h0001, 8'h00, 0, 1, "R3 set carry before logic");
        drive(4'd11, 16'h00FF, 16'h1234, 8'h00, 0, 1, "R6 not ignores b, clears carry");
        drive(4'd11, 16'hFFFF, 16'h0000, 8'h80, 1, 1, "R6 not imm ignored, R8 zero");
        // R9 hold with enable low
        drive(4'd2, 16'h7FFF, 16'h7FFF, 8'h00, 0, 1, "R3 set overflow");
        drive(4'd6, 16'h0000, 16'h0000, 8'h00, 0, 0, "R9 logic with enable low");
        drive(4'd3, 16'h0000, 16'h0001, 8'h00, 0, 0, "R9 sub with enable low");
        // R11 unused codes
        drive(4'd12, 16'h1234, 16'h5678, 8'h00, 0, 1, "R11 code 12");
        drive(4'd15, 16'hFFFF, 16'hFFFF, 8'h00, 0, 1, "R11 code 15");
        drive(4'd0, 16'h0000, 16'h0000, 8'h00, 0, 0, "R11 hi kept");
        @(negedge clk);
        flag_en = 1'b0;
        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule